// File: doc/BRIEF.md
# Bank Conflict Access Tracker

This block sits in front of a storage array split into several banks and decides, in the same cycle a request arrives, whether that request may start. Each request carries an array index. The low bits of the index select a bank. A bank that has accepted an access stays occupied for a fixed number of cycles, and any other request that lands on an occupied bank is refused. A refused requester sees no side effect and must present the request again in a later cycle.

Several requesters may present requests in one cycle. They are evaluated in port order, with port 0 first. A later port that names exactly the same index as an access that an earlier port started on that bank in the same cycle is also granted. This lets two consumers of one lookup share the access. A different index on that bank is refused. When the access latency parameter is zero, every valid request is granted and no bank state is kept.

Top module: `bank_gate`

## Requirements
- R1: With LATENCY = 0, every port whose valid bit is set is granted in that cycle, regardless of index or history.
- R2: The target bank is the request index modulo NUM_BANKS, a power of two, so only the low log2(NUM_BANKS) index bits matter. With NUM_BANKS = 1 every index targets the single bank.
- R3: A fresh grant to a bank in cycle t makes any request to that bank from another access refused in cycles t+1 through t+LATENCY-1. The bank accepts a new request from cycle t+LATENCY.
- R4: A busy bank has no effect on requests to other banks.
- R5: In the cycle of a fresh grant, a later port with the same index on the same bank is granted too. This second grant does not extend the busy window.
- R6: In the cycle of a fresh grant, a later port with a different index on the same bank is refused.
- R7: A port with its valid bit clear gets grant 0 and changes no bank state.
- R8: A refused request changes no bank state. The bank's busy window still ends where the original grant placed it.
- R9: A synchronous active-high reset frees every bank, so the first request to any bank after reset is granted.
- R10: When two ports with different indices target the same free bank in one cycle, the lower-numbered port wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NUM_REQ | Per-port request valid |
| req_idx | input | NUM_REQ*IDX_W | Per-port array index, port p in bits [p*IDX_W +: IDX_W] |
| grant | output | NUM_REQ | Per-port same-cycle grant |

## Verification
A busy counter that is wrong shows up on the next request to that bank. If it is released early, a request in the window t+1..t+LATENCY-1 is granted. If it is held late, a request at t+LATENCY is refused. Either error is visible within LATENCY cycles of the grant. A same-cycle claim that is lost or misrouted shows up in that very cycle as a wrong grant on a later port. A refused request that wrongly reloads a counter shows up as a refusal in the cycle where the original window should have ended.

// File: rtl/bank_gate_pkg.sv
package bank_gate_pkg;

   // Floor of log2 for elaboration-time sizing.
   function automatic int unsigned floor_log2(input int unsigned n);
      int unsigned r;
      r = 0;
      for (int unsigned v = n; v > 1; v = v >> 1) r++;
      return r;
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/bank_gate_map.sv
module bank_gate_map #(
   parameter int unsigned IDX_W     = 32,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned SEL_W     = 2
) (
   input  logic [IDX_W-1:0] idx,
   output logic [SEL_W-1:0] bank
);
   logic unused_idx;
   assign unused_idx = ^idx;

   generate
      if (NUM_BANKS == 1) begin : g_single
         assign bank = '0;
      end else begin : g_multi
         // power-of-two bank count: modulo is the low select bits
         assign bank = idx[SEL_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/bank_gate_slot.sv
module bank_gate_slot #(
   parameter int unsigned LATENCY = 3,
   parameter int unsigned CNT_W   = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic busy
);
   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (rst)
         remain_q <= '0;
      else if (start)
         remain_q <= CNT_W'(LATENCY - 1);
      else if (remain_q != '0)
         remain_q <= remain_q - 1'b1;
   end

   assign busy = (remain_q != '0);
endmodule

// File: rtl/bank_gate.sv
module bank_gate #(
   parameter int unsigned IDX_W     = 32,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned LATENCY   = 3,
   parameter int unsigned NUM_REQ   = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_REQ-1:0]         req_vld,
   input  logic [NUM_REQ*IDX_W-1:0]   req_idx,
   output logic [NUM_REQ-1:0]         grant
);
   import bank_gate_pkg::*;

   localparam int unsigned BANK_BITS = floor_log2(NUM_BANKS);
   localparam int unsigned SEL_W     = (BANK_BITS == 0) ? 1 : BANK_BITS;
   localparam int unsigned CNT_W     = (LATENCY <= 2) ? 1 : $clog2(LATENCY);

   // elaboration checks
   if (!is_pow2(NUM_BANKS)) begin : g_bad_banks
      $error("bank_gate: NUM_BANKS must be a power of two");
   end
   if (NUM_REQ < 1) begin : g_bad_req
      $error("bank_gate: NUM_REQ must be at least 1");
   end
   if (IDX_W < SEL_W) begin : g_bad_idx
      $error("bank_gate: IDX_W narrower than bank select");
   end

   generate
      if (LATENCY == 0) begin : g_pass
         logic unused_in;
         assign unused_in = clk ^ rst ^ (^req_idx);
         assign grant = req_vld;
      end else begin : g_track
         logic [SEL_W-1:0]     bank_of   [NUM_REQ];
         logic [NUM_BANKS-1:0] busy_q;
         logic [NUM_BANKS-1:0] claimed;
         logic [IDX_W-1:0]     claim_idx [NUM_BANKS];
         logic [NUM_REQ-1:0]   grant_c;

         for (genvar p = 0; p < NUM_REQ; p++) begin : g_map
            bank_gate_map #(
               .IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W)
            ) u_map (
               .idx (req_idx[p*IDX_W +: IDX_W]),
               .bank(bank_of[p])
            );
         end

         for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
            bank_gate_slot #(.LATENCY(LATENCY), .CNT_W(CNT_W)) u_slot (
               .clk  (clk),
               .rst  (rst),
               .start(claimed[b]),
               .busy (busy_q[b])
            );
         end

         // Ports resolved in order; a bank claimed earlier this cycle
         // is busy, except for a request repeating the claiming index.
         always_comb begin
            claimed = '0;
            grant_c = '0;
            for (int b = 0; b < NUM_BANKS; b++) claim_idx[b] = '0;
            for (int p = 0; p < NUM_REQ; p++) begin
               if (req_vld[p]) begin
                  if (!busy_q[bank_of[p]] && !claimed[bank_of[p]]) begin
                     grant_c[p]             = 1'b1;
                     claimed[bank_of[p]]    = 1'b1;
                     claim_idx[bank_of[p]]  = req_idx[p*IDX_W +: IDX_W];
                  end else if (claimed[bank_of[p]] &&
                               claim_idx[bank_of[p]] == req_idx[p*IDX_W +: IDX_W]) begin
                     grant_c[p] = 1'b1;
                  end
               end
            end
         end

         assign grant = grant_c;
      end
   endgenerate
endmodule

// File: rtl/bank_gate_chk.sv
module bank_gate_chk #(
   parameter int unsigned IDX_W     = 32,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned LATENCY   = 3,
   parameter int unsigned NUM_REQ   = 2
) (
   input logic                     clk,
   input logic                     rst,
   input logic [NUM_REQ-1:0]       req_vld,
   input logic [NUM_REQ*IDX_W-1:0] req_idx,
   input logic [NUM_REQ-1:0]       grant
);
   logic [IDX_W-1:0] idx0;
   logic [IDX_W-1:0] bk0;
   assign idx0 = req_idx[IDX_W-1:0];
   assign bk0  = idx0 % IDX_W'(NUM_BANKS);

   for (genvar p = 0; p < NUM_REQ; p++) begin : g_idle
      // R7
      a_r7_no_grant_idle: assert property (@(posedge clk) disable iff (rst)
         !req_vld[p] |-> !grant[p]);
   end

   // R9
   a_r9_free_after_reset: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && req_vld[0]) |-> grant[0]);

   if (LATENCY == 0) begin : g_zero
      // R1
      a_r1_zero_latency_pass: assert property (@(posedge clk) disable iff (rst)
         req_vld[0] |-> grant[0]);
   end

   if (LATENCY >= 2) begin : g_hold
      // R3
      a_r3_bank_held: assert property (@(posedge clk) disable iff (rst)
         (req_vld[0] && grant[0]) |=>
            (!(req_vld[0] && bk0 == $past(bk0)) || !grant[0]));
   end

   if (LATENCY > 0 && NUM_REQ >= 2) begin : g_pair
      logic [IDX_W-1:0] idx1;
      logic [IDX_W-1:0] bk1;
      assign idx1 = req_idx[2*IDX_W-1:IDX_W];
      assign bk1  = idx1 % IDX_W'(NUM_BANKS);
      // R5
      a_r5_repeat_granted: assert property (@(posedge clk) disable iff (rst)
         (req_vld[0] && grant[0] && req_vld[1] && idx1 == idx0) |-> grant[1]);
      // R6
      a_r6_clash_refused: assert property (@(posedge clk) disable iff (rst)
         (req_vld[0] && grant[0] && req_vld[1] && bk1 == bk0 && idx1 != idx0)
            |-> !grant[1]);
   end
endmodule

bind bank_gate bank_gate_chk #(
   .IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS), .LATENCY(LATENCY), .NUM_REQ(NUM_REQ)
) u_chk (
   .clk(clk), .rst(rst), .req_vld(req_vld), .req_idx(req_idx), .grant(grant)
);

// File: tb/bank_gate_tb_top.sv
module bank_gate_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int IW = 32;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [1:0]    vld = '0;
   logic [2*IW-1:0] idx = '0;
   logic [1:0] g_main, g_zero, g_one;

   always #(CLK_PERIOD/2) clk = ~clk;

   bank_gate #(.IDX_W(IW), .NUM_BANKS(4), .LATENCY(3), .NUM_REQ(2)) dut_i (
      .clk(clk), .rst(rst), .req_vld(vld), .req_idx(idx), .grant(g_main));
   bank_gate #(.IDX_W(IW), .NUM_BANKS(4), .LATENCY(0), .NUM_REQ(2)) dut_z (
      .clk(clk), .rst(rst), .req_vld(vld), .req_idx(idx), .grant(g_zero));
   bank_gate #(.IDX_W(IW), .NUM_BANKS(1), .LATENCY(2), .NUM_REQ(2)) dut_o (
      .clk(clk), .rst(rst), .req_vld(vld), .req_idx(idx), .grant(g_one));

   typedef struct {
      int         unit;
      logic [1:0] exp;
      string      tag;
   } exp_t;
   exp_t sb[$];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // timestamp reference model, one set of banks per instance
   int cyc = 0;
   bit has_m [3][4];
   int st_m  [3][4];
   int end_m [3][4];
   int idx_m [3][4];

   task automatic model_clear();
      for (int m = 0; m < 3; m++)
         for (int b = 0; b < 4; b++) has_m[m][b] = 0;
   endtask

   task automatic model_try(input int m, input int nb, input int lat,
                            input bit v, input int i, output bit g);
      int b;
      g = 0;
      if (!v) return;
      if (lat == 0) begin g = 1; return; end
      b = i % nb;
      if (has_m[m][b] && cyc <= end_m[m][b]) begin
         g = (st_m[m][b] == cyc) && (idx_m[m][b] == i);
      end else begin
         g = 1;
         has_m[m][b] = 1;
         st_m[m][b]  = cyc;
         end_m[m][b] = cyc + lat - 1;
         idx_m[m][b] = i;
      end
   endtask

   task automatic step(input bit v0, input int i0, input bit v1, input int i1,
                       input string tag);
      bit a, c;
      exp_t e;
      @(posedge clk);
      #1;
      vld = {v1, v0};
      idx = {IW'(i1), IW'(i0)};
      cyc++;
      model_try(0, 4, 3, v0, i0, a); model_try(0, 4, 3, v1, i1, c);
      e.unit = 0; e.exp = {c, a}; e.tag = tag; sb.push_back(e);
      model_try(1, 4, 0, v0, i0, a); model_try(1, 4, 0, v1, i1, c);
      e.unit = 1; e.exp = {c, a}; e.tag = "R1"; sb.push_back(e);
      model_try(2, 1, 2, v0, i0, a); model_try(2, 1, 2, v1, i1, c);
      e.unit = 2; e.exp = {c, a}; e.tag = "R2"; sb.push_back(e);
   endtask

   task automatic do_reset(input int n);
      @(posedge clk);
      #1;
      rst = 1'b1;
      vld = '0;
      repeat (n) @(posedge clk);
      #1;
      rst = 1'b0;
      model_clear();
   endtask

   // monitor: compares every queued expectation in its cycle
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         exp_t e;
         logic [1:0] got;
         e = sb.pop_front();
         got = (e.unit == 0) ? g_main : (e.unit == 1) ? g_zero : g_one;
         checks++;
         if (got !== e.exp) begin
            fails++;
            $display("FAIL %s unit %0d cycle %0d: grant=%b expected=%b",
                     e.tag, e.unit, cyc, got, e.exp);
         end
      end
   end

   initial begin
      model_clear();
      repeat (2) @(posedge clk);
      #1 rst = 1'b0;
      step(0, 0, 0, 0, "R7");           // reset state: nothing granted
      step(1, 5, 0, 0, "R3");           // bank1 granted, t
      step(1, 1, 1, 2, "R4");           // bank1 refused, bank2 free
      step(1, 9, 0, 0, "R2");           // upper bits differ, still bank1
      step(1, 13, 0, 0, "R8");          // t+3: refusals did not extend
      step(1, 6, 1, 6, "R5");           // same-cycle repeat on bank2
      step(1, 2, 0, 0, "R5");
      step(1, 10, 0, 0, "R5");
      step(1, 14, 0, 0, "R5");          // repeat did not extend window
      step(1, 7, 1, 3, "R6");           // bank3, different index refused
      step(0, 0, 1, 11, "R7");          // idle port0, port1 refused
      step(1, 4, 0, 0, "R7");           // bank0 untouched by idle port
      step(1, 8, 1, 12, "R10");         // fresh? bank0 busy: both refused
      step(0, 0, 0, 0, "R7");
      step(1, 8, 1, 12, "R10");         // bank0 free: port0 wins
      step(1, 1, 0, 0, "R9");           // bank1 busy before reset
      do_reset(2);
      step(1, 1, 1, 5, "R9");           // first request after reset granted
      for (int k = 0; k < 400; k++) begin
         int a0, a1;
         a0 = int'($urandom % 12);
         a1 = ($urandom % 3 == 0) ? a0 : int'($urandom % 12);
         step(($urandom % 4) != 0, a0, ($urandom % 3) != 0, a1, "R3");
      end
      @(posedge clk);
      #1 vld = '0;
      @(negedge clk);
      @(posedge clk);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule